// File: doc/BRIEF.md
# LCD Bias Ladder Fast-Charge Controller

This block produces the digital controls for the resistor ladder that sets the bias levels of an LCD driver. A reference clock is divided by a power-of-two ratio, picked by a 3-bit code, to give the waveform base tick. A duty counter groups a programmable number of base ticks into one frame and marks the last tick of each frame with a strobe. The clock code and the duty length are sampled at reset and then only at frame boundaries, so a frame never has mixed timing.

The ladder-select output chooses between the low-resistance ladder (high current) and the high-resistance ladder (low current). Two control bits choose the policy. High current can be held all the time. Low current can be held all the time. In fast-charge mode, high current is applied for a short timed pulse after each base tick, because the backplane and frontplane waveforms switch only on those ticks, and low current is used for the rest of the period. The pulse length is a fixed fraction of the base period, chosen by a 2-bit field.

Top module: `lcd_bias_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all counters, keeps `base_tick` and `frame_strobe` low, drives `ladder_hi` to 1 on the cycle after the reset edge, and loads `clk_sel` and `duty_len` as the active settings.
- R2: With active clock code n (0..7), `base_tick` is high for one cycle in every 2^(n+4) cycles. The first tick after reset comes on cycle 2^(n+4)-1.
- R3: A new `clk_sel` value takes effect only at a frame boundary. The base period that follows a frame strobe uses the code present on the strobe cycle, and a change at any other time leaves the tick spacing unchanged.
- R4: `frame_strobe` is high only together with `base_tick`, on every (d+1)-th tick, where d is the active `duty_len` (0..3). `duty_len` is also sampled only at frame boundaries.
- R5: When `low_cur`=0 and `fast_chg`=0, `ladder_hi` is 1 on the next cycle and stays 1.
- R6: When `low_cur`=1 and `fast_chg`=0, `ladder_hi` is 0 on the next cycle and stays 0.
- R7: When `fast_chg`=1, `ladder_hi` becomes 1 on the cycle after each base tick and stays 1 for L cycles, then returns to 0. L = P >> s, where P is the base period about to start and s = 5, 6, 7 for `fc_len` = 00, 01, 10. The code 11 also gives s = 7, and L is never less than 1.
- R8: When both `low_cur` and `fast_chg` are 1, fast-charge behaviour (R7) applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Base divider code n, ratio 2^(n+4) |
| duty_len | input | 2 | Frame length minus one, in base ticks |
| low_cur | input | 1 | Hold the low-current ladder when fast charge is off |
| fast_chg | input | 1 | Enable fast-charge pulses |
| fc_len | input | 2 | Fast-charge fraction: 00 P/32, 01 P/64, 10 and 11 P/128 |
| base_tick | output | 1 | One-cycle waveform base tick |
| frame_strobe | output | 1 | Marks the last base tick of a frame |
| ladder_hi | output | 1 | 1 selects the high-current ladder |

## Verification
The bench changes `clk_sel` and `duty_len` in the middle of frames. A design that applied them at once would move ticks or strobes away from the frame grid. It runs fast charge with the smallest divider codes, where P/128 falls below one cycle. A design that did not clamp the length to 1 would produce no pulse at all. It also uses the code 11, where a plain decode would give a pulse of the wrong length, and sets both mode bits together, where getting the precedence wrong leaves the ladder stuck in low current. Resets arrive in the middle of fast-charge pulses to catch counters or a ladder select that reset leaves stale.

// File: rtl/lcd_bias_pkg.sv
package lcd_bias_pkg;

    localparam int SEL_W      = 3;
    localparam int DUTY_W     = 2;
    localparam int FC_W       = 2;
    localparam int BASE_SHIFT = 4;
    localparam int FC_SHIFT   = 5;
    localparam int FC_MAX     = 2;
    localparam int CNT_W      = BASE_SHIFT + (1 << SEL_W);

    typedef logic [SEL_W-1:0]  clk_code_t;
    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [FC_W-1:0]   fc_code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        LAD_HIGH = 2'd0,
        LAD_LOW  = 2'd1,
        LAD_FAST = 2'd2
    } ladder_mode_e;

    typedef struct packed {
        logic tick;
        logic frame;
    } timing_s;

    // Length of one base period in reference cycles.
    function automatic cnt_t base_period(clk_code_t code);
        int sh;
        sh = int'(code) + BASE_SHIFT;
        return cnt_t'(1) << sh;
    endfunction

    // Fast-charge pulse length; never below one cycle.
    function automatic cnt_t pulse_len(clk_code_t code, fc_code_t fc);
        int   sh;
        cnt_t len;
        sh  = FC_SHIFT + ((int'(fc) > FC_MAX) ? FC_MAX : int'(fc));
        len = base_period(code) >> sh;
        if (len == '0) len = cnt_t'(1);
        return len;
    endfunction

    function automatic ladder_mode_e pick_mode(logic low, logic fast);
        if (fast)     return LAD_FAST;
        else if (low) return LAD_LOW;
        else          return LAD_HIGH;
    endfunction

endpackage

// File: rtl/lcd_base_div.sv
module lcd_base_div
    import lcd_bias_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clk_code_t code_in,
    input  logic      frame_end,
    output logic      tick,
    output clk_code_t code_now,
    output clk_code_t code_next
);
    cnt_t      cnt_q;
    clk_code_t code_q;

    assign tick      = (cnt_q == (base_period(code_q) - cnt_t'(1)));
    assign code_now  = code_q;
    assign code_next = frame_end ? code_in : code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= code_in;
        end else begin
            if (tick) cnt_q <= '0;
            else      cnt_q <= cnt_q + cnt_t'(1);
            if (frame_end) code_q <= code_in;
        end
    end
endmodule

// File: rtl/lcd_frame_ctr.sv
module lcd_frame_ctr
    import lcd_bias_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t duty_in,
    input  logic  tick,
    output logic  frame_end
);
    duty_t pos_q;
    duty_t len_q;

    assign frame_end = tick && (pos_q == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            len_q <= duty_in;
        end else if (frame_end) begin
            pos_q <= '0;
            len_q <= duty_in;
        end else if (tick) begin
            pos_q <= pos_q + duty_t'(1);
        end
    end
endmodule

// File: rtl/lcd_fc_timer.sv
module lcd_fc_timer
    import lcd_bias_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  clk_code_t code_next,
    input  fc_code_t  fc_code,
    input  logic      low_cur,
    input  logic      fast_chg,
    output logic      ladder_hi
);
    cnt_t         rem_q;
    cnt_t         rem_d;
    ladder_mode_e mode;
    logic         lad_d;
    logic         lad_q;

    always_comb begin
        if (tick)               rem_d = pulse_len(code_next, fc_code);
        else if (rem_q != '0)   rem_d = rem_q - cnt_t'(1);
        else                    rem_d = '0;
    end

    always_comb begin
        mode = pick_mode(low_cur, fast_chg);
        unique case (mode)
            LAD_FAST: lad_d = (rem_d != '0);
            LAD_LOW:  lad_d = 1'b0;
            default:  lad_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            lad_q <= 1'b1;
        end else begin
            rem_q <= rem_d;
            lad_q <= lad_d;
        end
    end

    assign ladder_hi = lad_q;
endmodule

// File: rtl/lcd_bias_ctrl.sv
module lcd_bias_ctrl
    import lcd_bias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    input  logic [1:0] duty_len,
    input  logic       low_cur,
    input  logic       fast_chg,
    input  logic [1:0] fc_len,
    output logic       base_tick,
    output logic       frame_strobe,
    output logic       ladder_hi
);
    timing_s   tm;
    clk_code_t code_now;
    clk_code_t code_next;

    lcd_base_div u_div (
        .clk       (clk),
        .rst       (rst),
        .code_in   (clk_sel),
        .frame_end (tm.frame),
        .tick      (tm.tick),
        .code_now  (code_now),
        .code_next (code_next)
    );

    lcd_frame_ctr u_frame (
        .clk       (clk),
        .rst       (rst),
        .duty_in   (duty_len),
        .tick      (tm.tick),
        .frame_end (tm.frame)
    );

    lcd_fc_timer u_fc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tm.tick),
        .code_next (code_next),
        .fc_code   (fc_len),
        .low_cur   (low_cur),
        .fast_chg  (fast_chg),
        .ladder_hi (ladder_hi)
    );

    assign base_tick    = tm.tick;
    assign frame_strobe = tm.frame;
endmodule

// File: rtl/lcd_bias_ctrl_chk.sv
module lcd_bias_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       low_cur,
    input logic       fast_chg,
    input logic       base_tick,
    input logic       frame_strobe,
    input logic       ladder_hi,
    input logic [2:0] code_now
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ladder_hi && !frame_strobe && !base_tick));

    p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> $stable(code_now));

    p_frame_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> base_tick);

    p_high_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!low_cur && !fast_chg) |=> ladder_hi);

    p_low_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (low_cur && !fast_chg) |=> !ladder_hi);

    p_fc_start_r7: assert property (@(posedge clk) disable iff (rst)
        (fast_chg && base_tick) |=> ladder_hi);

    p_fc_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (fast_chg && low_cur && base_tick) |=> ladder_hi);
endmodule

bind lcd_bias_ctrl lcd_bias_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .low_cur      (low_cur),
    .fast_chg     (fast_chg),
    .base_tick    (base_tick),
    .frame_strobe (frame_strobe),
    .ladder_hi    (ladder_hi),
    .code_now     (code_now)
);

// File: tb/lcd_bias_ctrl_tb.sv
module lcd_bias_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] clk_sel;
    logic [1:0] duty_len;
    logic       low_cur;
    logic       fast_chg;
    logic [1:0] fc_len;
    logic       base_tick;
    logic       frame_strobe;
    logic       ladder_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lcd_bias_ctrl dut_i (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .duty_len(duty_len),
        .low_cur(low_cur), .fast_chg(fast_chg), .fc_len(fc_len),
        .base_tick(base_tick), .frame_strobe(frame_strobe), .ladder_hi(ladder_hi)
    );

    // Reference model built from the requirements.
    function automatic int per_of(int n);
        return 1 << (n + 4);
    endfunction

    function automatic int fc_of(int n, int f);
        int s;
        int l;
        s = (f == 0) ? 5 : (f == 1) ? 6 : 7;
        l = per_of(n) >> s;
        return (l < 1) ? 1 : l;
    endfunction

    int    m_cnt, m_sel, m_pos, m_duty, m_rem;
    bit    m_lad;
    string m_tag = "R1";

    always @(posedge clk) begin
        bit t;
        bit f;
        int nsel;
        if (rst) begin
            m_cnt = 0; m_sel = clk_sel; m_pos = 0; m_duty = duty_len;
            m_rem = 0; m_lad = 1; m_tag = "R1";
        end else begin
            t = (m_cnt == per_of(m_sel) - 1);
            f = t && (m_pos == m_duty);
            nsel = f ? int'(clk_sel) : m_sel;
            m_cnt = t ? 0 : m_cnt + 1;
            if (f) begin m_sel = clk_sel; m_duty = duty_len; m_pos = 0; end
            else if (t) m_pos = m_pos + 1;
            if (t) m_rem = fc_of(nsel, fc_len);
            else if (m_rem > 0) m_rem = m_rem - 1;
            if (fast_chg) begin
                m_lad = (m_rem != 0);
                m_tag = low_cur ? "R8" : "R7";
            end else begin
                m_lad = !low_cur;
                m_tag = low_cur ? "R6" : "R5";
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        bit et;
        if (!finished) begin
            cycles++;
            et = (m_cnt == per_of(m_sel) - 1);
            check("R2,R3 base_tick", base_tick, et);
            check("R4 frame_strobe", frame_strobe, et && (m_pos == m_duty));
            check({m_tag, " ladder_hi"}, ladder_hi, m_lad);
            if (cycles > 200000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
                finished = 1;
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        // R1: explicit reset state right after release
        #1;
        check("R1 ladder_hi after reset", ladder_hi, 1);
        check("R1 base_tick after reset", base_tick, 0);
        check("R1 frame_strobe after reset", frame_strobe, 0);
    endtask

    initial begin
        void'($urandom(32'd7411));
        rst = 1'b1; clk_sel = 3'd0; duty_len = 2'd2;
        low_cur = 1'b0; fast_chg = 1'b0; fc_len = 2'd0;
        #1;
        do_reset();

        // R2 R5: smallest divider, high-current hold
        wait_cyc(200);
        // R6: low-current hold
        low_cur = 1'b1; wait_cyc(100);
        // R7: fast charge with clamped length and code 11
        fast_chg = 1'b1; low_cur = 1'b0; fc_len = 2'd3; wait_cyc(200);
        // R8: both bits set
        low_cur = 1'b1; fc_len = 2'd0; clk_sel = 3'd5; wait_cyc(3000);
        // R3 R4: change code and duty mid-frame
        clk_sel = 3'd1; duty_len = 2'd0; wait_cyc(50);
        clk_sel = 3'd3; duty_len = 2'd3; wait_cyc(1500);
        // R1: reset in the middle of a pulse
        fast_chg = 1'b1; clk_sel = 3'd6; wait_cyc(1030);
        do_reset();
        wait_cyc(2000);

        // Constrained random segments
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom_range(0, 9);
            clk_sel  = (r < 7) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
            duty_len = 2'($urandom_range(0, 3));
            low_cur  = 1'($urandom_range(0, 1));
            fast_chg = 1'($urandom_range(0, 2) != 0);
            fc_len   = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) do_reset();
            wait_cyc($urandom_range(50, 1500));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule